// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a serial EEPROM over a three-wire bus: a clock output and one bidirectional data line. The chip select is driven elsewhere. Firmware first loads an 8-bit data register, then writes a control register. The control write starts one command of 0 to 8 clock pulses. The command either shifts the data register out on the data line or shifts bits from the line into it. A command can also release the data line after its last clock, and it can hold off completion until the EEPROM signals ready by pulling the data line high.

The block shows a busy flag while a command runs. It pulses an interrupt for one cycle when busy falls. The serial clock idles low. Each clock pulse spends `HALF_DIV` system cycles low and then `HALF_DIV` cycles high. Outgoing data changes only while the clock is low, and incoming data is sampled on the rising clock edge. The data input is taken as already synchronous to the system clock.

Top module: `eep3_master`

## Requirements
- R1: After reset: `sclk`=0, `sd_out`=0, `sd_oe`=1, `irq`=0, data register 0x00 and control register 0x00.
- R2: A register write with `reg_addr`=1 while idle starts a command, and busy reads as 1 from the following cycle. The readback at address 1 is {wait-for-ready bit 7, busy bit 6, release bit 5, read-select bit 4, count bits 3:0}, and the data register reads at address 0.
- R3: A command with count N issues exactly N clock pulses, each `HALF_DIV` cycles low then `HALF_DIV` cycles high. Busy lasts 2·N·`HALF_DIV` cycles. A count above 8 is stored and executed as 8.
- R4: In write mode (bit 4 = 0), the top N bits of the data register go out MSB first with `sd_oe`=1. `sd_out` holds steady while `sclk` is high, and the register is left shifted left by N with zeros filled in.
- R5: In read mode (bit 4 = 1), `sd_oe`=0 during the clocks. `sd_in` is sampled at each rising clock edge, and the data register shifts left once per bit, so its low N bits hold the received bits MSB first.
- R6: From the cycle after the last rising clock edge, `sd_oe` equals the inverse of the release bit (bit 5).
- R7: A count of 0 issues no clock pulse. `sd_oe` becomes the inverse of the release bit, and busy lasts one cycle unless R9 applies.
- R8: `irq` is high for exactly one cycle: the first cycle in which busy reads 0 after a command.
- R9: With wait-for-ready (bit 7) and release (bit 5) both set, busy stays high after the clocks end until `sd_in` is seen going from 0 to 1. With release clear, wait-for-ready has no effect.
- R10: Writes to either register while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = data register, 1 = control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sclk | output | 1 | Serial clock, idles low |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_in | input | 1 | Data line input |
| irq | output | 1 | One-cycle pulse when busy falls |

## Verification
The bench goes after the count boundaries 0, 8 and 15. A design that miscounts or fails to clamp would issue a wrong number of pulses or show a wrong busy length. Read tests use partial counts, where a design that left-justified the bits or shifted once too often would leave a wrong register value. The bench also checks the release timing at the last rising edge and the wait-for-ready hold with a line that stays low first. A design that released late would show the wrong enable at that edge, and one that ignored the ready wait would drop busy too early. Writes made mid-command must leave both the count and the data untouched.

// File: rtl/eep3_pkg.sv
package eep3_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;
  localparam int CNT_MAX = DATA_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_WAIT, ST_FIN
  } eep3_state_e;

  // Counts beyond the register width collapse to the width.
  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] raw);
    return (raw > CNT_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : raw;
  endfunction

  function automatic logic [7:0] ctrl_pack(input logic wfr, input logic busy,
                                           input logic rel, input logic rd,
                                           input logic [CNT_W-1:0] cnt);
    return {wfr, busy, rel, rd, cnt};
  endfunction
endpackage

// File: rtl/eep3_div.sv
module eep3_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV + 1);
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HALF_DIV)); // R3
endmodule

// File: rtl/eep3_shreg.sv
module eep3_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], shift_in};
  end

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R10
endmodule

// File: rtl/eep3_master.sv
module eep3_master
  import eep3_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sclk,
  output logic       sd_out,
  output logic       sd_oe,
  input  logic       sd_in,
  output logic       irq
);
  eep3_state_e state_q;
  logic [CNT_W-1:0] cnt_q, left_q;
  logic wfr_q, rel_q, rd_q;
  logic sclk_q, sd_out_q, oe_q, irq_q, sd_in_q;
  logic [DATA_W-1:0] data_q;
  logic tick, busy;

  // Named events
  logic start_cmd, data_load, rise_ev, fall_ev, last_rise, bits_done;
  logic ready_seen, end_ev, hold_ready;
  logic [CNT_W-1:0] new_cnt;

  assign busy       = (state_q != ST_IDLE);
  assign new_cnt    = clamp_count(reg_wdata[3:0]);
  assign start_cmd  = reg_wr && reg_addr && !busy;
  assign data_load  = reg_wr && !reg_addr && !busy;
  assign rise_ev    = (state_q == ST_LOW) && tick;
  assign fall_ev    = (state_q == ST_HIGH) && tick;
  assign last_rise  = rise_ev && (left_q == CNT_W'(1));
  assign bits_done  = (fall_ev && (left_q == '0)) || (state_q == ST_FIN);
  assign hold_ready = wfr_q && rel_q;
  assign ready_seen = (state_q == ST_WAIT) && sd_in && !sd_in_q;
  assign end_ev     = (bits_done && !hold_ready) || ready_seen;

  eep3_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n),
    .run((state_q == ST_LOW) || (state_q == ST_HIGH)),
    .tick(tick)
  );

  eep3_shreg #(.W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .load(data_load), .load_val(reg_wdata),
    .shift(rise_ev), .shift_in(rd_q ? sd_in : 1'b0),
    .q(data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      left_q   <= '0;
      wfr_q    <= 1'b0;
      rel_q    <= 1'b0;
      rd_q     <= 1'b0;
      sclk_q   <= 1'b0;
      sd_out_q <= 1'b0;
      oe_q     <= 1'b1;
      irq_q    <= 1'b0;
      sd_in_q  <= 1'b0;
    end else begin
      sd_in_q <= sd_in;
      irq_q   <= end_ev;
      if (start_cmd) begin
        wfr_q    <= reg_wdata[7];
        rel_q    <= reg_wdata[5];
        rd_q     <= reg_wdata[4];
        cnt_q    <= new_cnt;
        left_q   <= new_cnt;
        sd_out_q <= data_q[DATA_W-1];
        if (new_cnt == '0) begin
          state_q <= ST_FIN;
          oe_q    <= !reg_wdata[5];
        end else begin
          state_q <= ST_LOW;
          oe_q    <= !reg_wdata[4];
        end
      end else begin
        if (rise_ev) begin
          sclk_q  <= 1'b1;
          left_q  <= left_q - 1'b1;
          state_q <= ST_HIGH;
        end
        if (last_rise) oe_q <= !rel_q;
        if (fall_ev) begin
          sclk_q <= 1'b0;
          if (left_q != '0) begin
            sd_out_q <= data_q[DATA_W-1];
            state_q  <= ST_LOW;
          end
        end
        if (bits_done) state_q <= hold_ready ? ST_WAIT : ST_IDLE;
        if (ready_seen) state_q <= ST_IDLE;
      end
    end
  end

  assign sclk      = sclk_q;
  assign sd_out    = sd_out_q;
  assign sd_oe     = oe_q;
  assign irq       = irq_q;
  assign reg_rdata = reg_addr ? ctrl_pack(wfr_q, busy, rel_q, rd_q, cnt_q) : data_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R3
  AST_CNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX)); // R3
  AST_SDOUT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sd_out)); // R4
  AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_rise |=> (sd_oe == !rel_q)); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy))); // R8
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr) |=> $stable(cnt_q)); // R10
  AST_WAIT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> rel_q); // R9
endmodule

// File: tb/tb_eep3_master.sv
module tb_eep3_master;
  localparam int CLK_PERIOD = 10;
  localparam int HD = 2;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_addr = 0, sd_in = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic sclk, sd_out, sd_oe, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  eep3_master #(.HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
    .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  // Runs one command and follows it as the EEPROM would.
  task automatic run_cmd(input string req, input logic [7:0] init, input logic [7:0] ctrl,
                         input logic [7:0] ee_byte);
    int n, rises, cyc; logic prev, held, rdm, rel; logic [7:0] got, v, expd; logic [15:0] wide;
    n = (ctrl[3:0] > 8) ? 8 : ctrl[3:0];
    rdm = ctrl[4]; rel = ctrl[5];
    wr(0, init);
    sd_in = 0;
    wr(1, ctrl);
    rd_reg(1, v);
    check({req, " R2 ctrl readback"}, v, {ctrl[7], 1'b1, ctrl[5], rdm, 4'(n)});
    rises = 0; cyc = 0; prev = sclk; got = 0; held = 0;
    while (reg_rdata[6] && cyc < 500) begin
      if (rdm && !sclk && rises < n) sd_in = ee_byte[7 - rises];
      if (sclk && !prev) begin
        rises++;
        got = {got[6:0], sd_out}; held = sd_out;
        check({req, " R6/R4/R5 oe at rise"}, sd_oe, (rises == n) ? !rel : !rdm);
      end else if (sclk && prev) begin
        check({req, " R4 sd_out held high"}, sd_out, held);
      end
      prev = sclk; cyc++;
      @(negedge clk); rd_reg(1, v);
    end
    check({req, " R3 clock count"}, rises, n);
    check({req, " R3/R7 busy cycles"}, cyc, (n == 0) ? 1 : 2*n*HD);
    check({req, " R8 irq at busy fall"}, irq, 1);
    check({req, " R6/R7 final oe"}, sd_oe, !rel);
    rd_reg(0, v);
    if (rdm) begin
      wide = ({8'h0, init} << n) | 16'(ee_byte >> (8 - n));
      check({req, " R5 read data"}, v, wide[7:0]);
    end else begin
      wide = {8'h0, init} << n;
      check({req, " R4 shifted data"}, v, wide[7:0]);
      if (n > 0) check({req, " R4 bits sent"}, got, 8'(init >> (8 - n)));
    end
    @(negedge clk);
    check({req, " R8 irq one cycle"}, irq, 0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 sclk", sclk, 0); check("R1 sd_out", sd_out, 0);
    check("R1 sd_oe", sd_oe, 1); check("R1 irq", irq, 0);
    rd_reg(0, v); check("R1 data", v, 0);
    rd_reg(1, v); check("R1 ctrl", v, 0);
  endtask

  task automatic t_busy_writes();
    logic [7:0] v;
    wr(0, 8'hC3);
    wr(1, 8'h08);
    @(negedge clk); reg_wr = 1; reg_addr = 1; reg_wdata = 8'h31;
    @(negedge clk); reg_addr = 0; reg_wdata = 8'h55;
    @(negedge clk); reg_wr = 0;
    rd_reg(1, v); check("R10 ctrl unchanged", v, 8'h48);
    while (reg_rdata[6]) begin @(negedge clk); rd_reg(1, v); end
    rd_reg(0, v); check("R10 data unchanged", v, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_wait_ready();
    logic [7:0] v;
    wr(0, 8'hA0);
    sd_in = 0;
    wr(1, 8'hA2);
    repeat (2*2*HD + 6) @(negedge clk);
    rd_reg(1, v); check("R9 busy held while line low", v[6], 1);
    check("R9 no early irq", irq, 0);
    check("R9 released line", sd_oe, 0);
    sd_in = 1;
    @(negedge clk); rd_reg(1, v);
    check("R9 busy falls after rising edge", v[6], 0);
    check("R9/R8 irq", irq, 1);
    sd_in = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*3); @(negedge clk); rst_n = 1;
    t_reset();
    run_cmd("write8",   8'hB5, 8'h08, 8'h00);
    run_cmd("write6rel",8'h9C, 8'h26, 8'h00);
    run_cmd("read5",    8'h5A, 8'h35, 8'hB3);
    run_cmd("read8",    8'hFF, 8'h18, 8'h6D);
    run_cmd("cnt0drive",8'h12, 8'h00, 8'h00);
    run_cmd("cnt0rel",  8'h12, 8'h20, 8'h00);
    run_cmd("clamp15",  8'hE1, 8'h0F, 8'h00);
    run_cmd("wfrNoRel R9", 8'h3C, 8'h83, 8'h00);
    run_cmd("read1",    8'h00, 8'h11, 8'h80);
    t_busy_writes();
    t_wait_ready();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD*100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule